// File: doc/BRIEF.md
# DRAM Refresh Mode Detector and Row Counter

This block watches the strobe lines of an asynchronous DRAM core, already synchronized to the system clock, and sorts every row activation into one of five kinds. The kinds are a refresh of the row on the address pins, a refresh addressed by an internal counter with CAS ahead of RAS, a hidden refresh that follows a read while CAS stays low, a long refresh that becomes autonomous self-refresh, and an ordinary access. The kind is decided by the order in which the RAS and CAS edges arrive. For each refresh it emits a one-cycle strobe together with the row that is to be refreshed. It also tells the data path whether the output drivers must be turned off.

The internally addressed modes share one row counter. The counter steps after each completed internal refresh and after each autonomous self-refresh tick. A configuration input selects how far it runs before it wraps: 4096 rows or 2048 rows. The block also keeps a count of completed activations after reset and reports when the start-up sequence of eight has been met. The array itself and retention timing belong to other blocks.

Top module: `rfr_mode_detect`

## Requirements
- R1: After reset the mode code is 0 (idle), `rfsh_stb` is 0, `out_off` is 0, `init_done` is 0 and the internal counter holds row 0.
- R2: RAS falling while `cas_low` is 0 gives mode 1 (row-addressed) with `out_off` 1 from the next cycle. If RAS then rises with CAS still high, `rfsh_stb` pulses for one cycle in the cycle after the rise, with `rfsh_row` equal to the address latched at the fall (bit 11 cleared when `half_rows` is 1), and the mode returns to 0. The internal counter does not change.
- R3: CAS falling while in mode 1 turns the activation into a normal access, mode 2, with `out_off` 0 and no strobe for the whole activation.
- R4: RAS falling while `cas_low` is 1 and no hidden condition is pending gives mode 3 and a strobe in the next cycle, with `rfsh_row` equal to the counter. `out_off` is 1. The counter advances by one after RAS rises.
- R5: If a mode-2 access ends with RAS rising while CAS stays low, the next RAS fall with CAS still low gives mode 4 (hidden), a strobe carrying the counter row, and `out_off` 0. The counter advances after RAS rises. CAS going high in between cancels the hidden condition, so the next such fall is an R4 refresh.
- R6: A mode-3 activation whose RAS stays low for SELF_ENTRY_CYC cycles after the mode-3 cycle becomes mode 5 (self-refresh), with `out_off` 1.
- R7: In mode 5 a strobe carrying the counter row fires every SELF_GAP_CYC cycles, and the counter advances after each strobe. RAS rising returns the mode to 0 and advances the counter once more.
- R8: With `half_rows` 0 the counter runs 0..4095 and wraps to 0. With `half_rows` 1 it runs 0..2047 and wraps to 0, and reported rows never have bit 11 set.
- R9: `init_done` rises after the eighth completed activation of any kind since reset and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Synchronized row strobe, low = active |
| cas_low | input | 1 | High when any of the column strobes is low |
| row_addr | input | ROW_BITS | Row address pins |
| half_rows | input | 1 | 1 selects the 2048-row variant |
| rfsh_row | output | ROW_BITS | Row of the latest refresh strobe |
| rfsh_stb | output | 1 | One-cycle refresh request |
| mode | output | 3 | 0 idle, 1 row-addressed, 2 access, 3 CAS-first, 4 hidden, 5 self |
| out_off | output | 1 | Request to turn the data outputs off |
| init_done | output | 1 | Start-up activation count reached |

## Verification
A counter that skipped, stuck or wrapped at the wrong bound shows up in the row of the very next internally addressed strobe. A random mix of refresh kinds therefore exposes it within one activation. A hidden-condition flag that was wrong shows one activation later, as mode 4 where mode 3 was due or the reverse, and also as a flipped `out_off`. Timer errors show as a self-refresh entry or a strobe arriving one cycle early or late against cycle-counted expectations. Long runs through both wrap points check the counter bounds directly.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

    typedef enum logic [2:0] {
        MD_IDLE   = 3'd0,
        MD_ROW    = 3'd1,
        MD_ACCESS = 3'd2,
        MD_CBR    = 3'd3,
        MD_HIDDEN = 3'd4,
        MD_SELF   = 3'd5
    } rfr_mode_e;

    // Modes in which the data outputs must be released
    function automatic logic mode_hiz(rfr_mode_e m);
        return (m == MD_ROW) || (m == MD_CBR) || (m == MD_SELF);
    endfunction

endpackage

// File: rtl/rfr_tick_timer.sv
module rfr_tick_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = run && (cnt_q == CW'(LIMIT - 1));
        cnt_d = '0;
        if (run && !hit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R6/R7: the count never runs past its limit
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

    // R6/R7: dropping run clears the count for the next window
    a_r6_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/rfr_row_counter.sv
module rfr_row_counter #(
    parameter int ROW_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    input  logic                half_rows,
    output logic [ROW_BITS-1:0] row
);
    localparam logic [ROW_BITS-1:0] FULL_MASK = '1;
    localparam logic [ROW_BITS-1:0] HALF_MASK = FULL_MASK >> 1;

    logic [ROW_BITS-1:0] mask;
    logic [ROW_BITS-1:0] cnt_d, cnt_q;

    always_comb begin
        mask  = half_rows ? HALF_MASK : FULL_MASK;
        row   = cnt_q & mask;
        cnt_d = cnt_q;
        if (inc) begin
            cnt_d = (cnt_q + 1'b1) & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R8: top of the full range wraps to zero
    a_r8_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !half_rows && (row == FULL_MASK)) |=> (row == '0));

    // R8: top of the half range wraps to zero
    a_r8_half_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && half_rows && (row == HALF_MASK)) |=> (row == '0));

    // R2: without a step the row holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && $stable(half_rows)) |=> $stable(row));

endmodule

// File: rtl/rfr_mode_detect.sv
module rfr_mode_detect #(
    parameter int ROW_BITS       = 12,
    parameter int SELF_ENTRY_CYC = 20000,
    parameter int SELF_GAP_CYC   = 64,
    parameter int INIT_CYCLES    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_low,
    input  logic [ROW_BITS-1:0] row_addr,
    input  logic                half_rows,
    output logic [ROW_BITS-1:0] rfsh_row,
    output logic                rfsh_stb,
    output logic [2:0]          mode,
    output logic                out_off,
    output logic                init_done
);
    import rfr_pkg::*;

    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [ROW_BITS-1:0] FULL_MASK = '1;

    typedef struct packed {
        rfr_mode_e           mode;
        logic                ras_prev;
        logic                held;
        logic [ROW_BITS-1:0] lat_row;
        logic [ROW_BITS-1:0] out_row;
        logic                stb;
        logic                hiz;
        logic [INIT_W-1:0]   init_cnt;
    } rfr_state_t;

    rfr_state_t st_d, st_q;

    logic                cnt_inc;
    logic [ROW_BITS-1:0] cnt_row;
    logic [ROW_BITS-1:0] row_mask;
    logic                entry_hit;
    logic                gap_hit;
    logic                ras_fall;
    logic                ras_rise;
    logic                act_done;

    rfr_row_counter #(.ROW_BITS(ROW_BITS)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (cnt_inc),
        .half_rows (half_rows),
        .row       (cnt_row)
    );

    rfr_tick_timer #(.LIMIT(SELF_ENTRY_CYC)) u_entry_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.mode == MD_CBR),
        .hit   (entry_hit)
    );

    rfr_tick_timer #(.LIMIT(SELF_GAP_CYC)) u_gap_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.mode == MD_SELF),
        .hit   (gap_hit)
    );

    always_comb begin
        row_mask = half_rows ? (FULL_MASK >> 1) : FULL_MASK;
        ras_fall = st_q.ras_prev && !ras_n;
        ras_rise = !st_q.ras_prev && ras_n;
        act_done = 1'b0;
        cnt_inc  = 1'b0;

        st_d          = st_q;
        st_d.stb      = 1'b0;
        st_d.ras_prev = ras_n;
        if (!cas_low) begin
            st_d.held = 1'b0;
        end

        case (st_q.mode)
            MD_IDLE: begin
                if (ras_fall) begin
                    if (cas_low) begin
                        st_d.mode    = st_q.held ? MD_HIDDEN : MD_CBR;
                        st_d.stb     = 1'b1;
                        st_d.out_row = cnt_row;
                    end else begin
                        st_d.mode    = MD_ROW;
                        st_d.lat_row = row_addr & row_mask;
                    end
                end
            end
            MD_ROW: begin
                if (ras_rise) begin
                    st_d.mode    = MD_IDLE;
                    st_d.stb     = 1'b1;
                    st_d.out_row = st_q.lat_row;
                    act_done     = 1'b1;
                end else if (cas_low) begin
                    st_d.mode = MD_ACCESS;
                end
            end
            MD_ACCESS: begin
                if (ras_rise) begin
                    st_d.mode = MD_IDLE;
                    st_d.held = cas_low;
                    act_done  = 1'b1;
                end
            end
            MD_CBR, MD_HIDDEN: begin
                if (ras_rise) begin
                    st_d.mode = MD_IDLE;
                    cnt_inc   = 1'b1;
                    act_done  = 1'b1;
                end else if ((st_q.mode == MD_CBR) && entry_hit) begin
                    st_d.mode = MD_SELF;
                end
            end
            MD_SELF: begin
                if (ras_rise) begin
                    st_d.mode = MD_IDLE;
                    cnt_inc   = 1'b1;
                    act_done  = 1'b1;
                end else if (gap_hit) begin
                    st_d.stb     = 1'b1;
                    st_d.out_row = cnt_row;
                    cnt_inc      = 1'b1;
                end
            end
            default: begin
                st_d.mode = MD_IDLE;
            end
        endcase

        if (act_done && (st_q.init_cnt != INIT_W'(INIT_CYCLES))) begin
            st_d.init_cnt = st_q.init_cnt + 1'b1;
        end
        st_d.hiz = mode_hiz(st_d.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_IDLE, ras_prev: 1'b1, held: 1'b0,
                      lat_row: '0, out_row: '0, stb: 1'b0, hiz: 1'b0,
                      init_cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rfsh_row  = st_q.out_row;
    assign rfsh_stb  = st_q.stb;
    assign mode      = st_q.mode;
    assign out_off   = st_q.hiz;
    assign init_done = (st_q.init_cnt == INIT_W'(INIT_CYCLES));

    // R2: a row-addressed activation closing strobes its latched row
    a_r2_row_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MD_ROW) && ras_n) |=> (rfsh_stb && (rfsh_row == $past(st_q.lat_row))));

    // R3: an access never requests a refresh
    a_r3_access_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |-> (!rfsh_stb && !out_off));

    // R4: CAS ahead of RAS with no pending hidden state starts a counter refresh
    a_r4_cbr_start: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd0) && st_q.ras_prev && !ras_n && cas_low && !st_q.held)
        |=> ((mode == 3'd3) && rfsh_stb && out_off && (rfsh_row == $past(cnt_row))));

    // R5: hidden refresh keeps the outputs driven
    a_r5_hidden_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |-> !out_off);

    // R6: self-refresh is reached only from a CAS-first refresh
    a_r6_self_from_cbr: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd5) && ($past(mode) != 3'd5)) |-> ($past(mode) == 3'd3));

    // R7: RAS rising ends self-refresh at once
    a_r7_self_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd5) && ras_n) |=> (mode == 3'd0));

    // R9: the start-up flag never drops
    a_r9_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

endmodule

// File: tb/rfr_mode_detect_bench.sv
module rfr_mode_detect_bench;

    localparam int RB    = 12;
    localparam int ENTRY = 40;
    localparam int GAP   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1;
    logic          cas_low = 1'b0;
    logic [RB-1:0] row_addr = '0;
    logic          half_rows = 1'b0;
    logic [RB-1:0] rfsh_row;
    logic          rfsh_stb;
    logic [2:0]    mode;
    logic          out_off;
    logic          init_done;

    int errors = 0;
    int checks = 0;
    int exp_cnt = 0;
    int acts = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rfr_mode_detect #(
        .ROW_BITS(RB), .SELF_ENTRY_CYC(ENTRY), .SELF_GAP_CYC(GAP), .INIT_CYCLES(8)
    ) u_rfr_mode_detect (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_low(cas_low),
        .row_addr(row_addr), .half_rows(half_rows), .rfsh_row(rfsh_row),
        .rfsh_stb(rfsh_stb), .mode(mode), .out_off(out_off), .init_done(init_done)
    );

    function automatic int msk(bit h);
        return h ? 2047 : 4095;
    endfunction

    function automatic int nxt(int c, bit h);
        return ((c & msk(h)) + 1) & msk(h);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, return at the next falling edge
    task automatic drv(bit r, bit c, int a);
        ras_n    = r;
        cas_low  = c;
        row_addr = RB'(a);
        @(negedge clk);
    endtask

    task automatic act_end();
        acts++;
        chk("R9 init_done", int'(init_done), (acts >= 8) ? 1 : 0);
    endtask

    task automatic do_row_only(int a);
        drv(0, 0, a);
        chk("R2 mode", int'(mode), 1);
        chk("R2 out_off", int'(out_off), 1);
        chk("R2 no early strobe", int'(rfsh_stb), 0);
        drv(1, 0, 0);
        chk("R2 strobe", int'(rfsh_stb), 1);
        chk("R2 row", int'(rfsh_row), a & msk(half_rows));
        chk("R2 back idle", int'(mode), 0);
        act_end();
        drv(1, 0, 0);
        chk("R2 single pulse", int'(rfsh_stb), 0);
    endtask

    task automatic do_cbr(int hold);
        drv(1, 0, 0);
        drv(1, 1, 0);
        drv(0, 1, 0);
        chk("R4 mode", int'(mode), 3);
        chk("R4 strobe", int'(rfsh_stb), 1);
        chk("R4 row", int'(rfsh_row), exp_cnt & msk(half_rows));
        chk("R4 out_off", int'(out_off), 1);
        for (int i = 0; i < hold; i++) drv(0, 1, 0);
        drv(1, 1, 0);
        chk("R4 idle after", int'(mode), 0);
        exp_cnt = nxt(exp_cnt, half_rows);
        act_end();
        drv(1, 0, 0);
    endtask

    task automatic do_access(int a, bit keep);
        drv(0, 0, a);
        drv(0, 1, a);
        chk("R3 mode", int'(mode), 2);
        chk("R3 out_off", int'(out_off), 0);
        chk("R3 no strobe", int'(rfsh_stb), 0);
        drv(1, keep, 0);
        chk("R3 idle", int'(mode), 0);
        chk("R3 no strobe at end", int'(rfsh_stb), 0);
        act_end();
    endtask

    task automatic do_hidden();
        drv(0, 1, 0);
        chk("R5 mode", int'(mode), 4);
        chk("R5 strobe", int'(rfsh_stb), 1);
        chk("R5 row", int'(rfsh_row), exp_cnt & msk(half_rows));
        chk("R5 out_off", int'(out_off), 0);
        drv(1, 1, 0);
        exp_cnt = nxt(exp_cnt, half_rows);
        act_end();
    endtask

    task automatic do_self(int n);
        drv(1, 0, 0);
        drv(1, 1, 0);
        drv(0, 1, 0);
        chk("R6 cbr first", int'(mode), 3);
        for (int j = 1; j < ENTRY; j++) drv(0, 1, 0);
        chk("R6 not yet self", int'(mode), 3);
        drv(0, 1, 0);
        chk("R6 self mode", int'(mode), 5);
        chk("R6 out_off", int'(out_off), 1);
        for (int m = 0; m < n; m++) begin
            for (int g = 1; g < GAP; g++) begin
                drv(0, 1, 0);
                if (rfsh_stb) chk("R7 strobe early", 1, 0);
            end
            drv(0, 1, 0);
            chk("R7 strobe", int'(rfsh_stb), 1);
            chk("R7/R8 row", int'(rfsh_row), exp_cnt & msk(half_rows));
            exp_cnt = nxt(exp_cnt, half_rows);
        end
        drv(1, 1, 0);
        chk("R7 exit", int'(mode), 0);
        exp_cnt = nxt(exp_cnt, half_rows);
        act_end();
        drv(1, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        chk("R1 mode", int'(mode), 0);
        chk("R1 strobe", int'(rfsh_stb), 0);
        chk("R1 out_off", int'(out_off), 0);
        chk("R1 init_done", int'(init_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: counter starts at row 0, seen in the first CBR row
        do_cbr(0);
        do_row_only(12'hABC);
        do_cbr(2);                  // R2: counter untouched by the RAS-only cycle
        do_access(5, 1);
        do_hidden();
        drv(1, 1, 0);
        do_hidden();                // repeated hidden while CAS stays low
        drv(1, 0, 0);
        // R5 cancel: CAS rises after the access, so the next is CAS-first
        do_access(9, 1);
        drv(1, 0, 0);
        drv(1, 1, 0);
        drv(0, 1, 0);
        chk("R5 cancel gives cbr", int'(mode), 3);
        chk("R5 cancel out_off", int'(out_off), 1);
        drv(1, 1, 0);
        exp_cnt = nxt(exp_cnt, half_rows);
        act_end();
        drv(1, 0, 0);

        // R6: hold just short of entry stays CAS-first
        do_cbr(ENTRY - 1);
        do_self(3);

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int k;
            half_rows = 1'($urandom % 2);
            k = int'($urandom % 5);
            case (k)
                0: do_row_only(int'($urandom % 4096));
                1: do_cbr(int'($urandom % 4));
                2: do_access(int'($urandom % 4096), 0);
                3: begin do_access(int'($urandom % 4096), 1); do_hidden(); drv(1, 0, 0); end
                default: begin do_access(int'($urandom % 4096), 1); drv(1, 0, 0); end
            endcase
        end

        // R8: wrap through both ranges
        half_rows = 1'b1;
        do_self(2050);
        half_rows = 1'b0;
        do_self(4100);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule